// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block gives a host indirect access to a small bank of 8-bit configuration entries through two ports: a selector that holds an index and a data port that reads or writes the entry that index points at. A third location holds a free scratch byte with no defined purpose. None of the stored bits drives any other logic; the block is pure storage behind a register window.

The host bus is synchronous. Each cycle it presents a word offset, a write enable, a read enable, a 4-bit byte-lane mask and 32-bit write data, of which only the low byte is used. Reads are registered: the data shows up one clock after the read enable, together with a one-cycle valid strobe. An index that points past the end of the bank is guarded. Writes through the data port are then dropped, and reads return zero.

Top module: `cfg_window`

## Requirements
- R1: Synchronous active-high reset clears the scratch byte, the index and all 16 bank entries to zero, and holds `bus_rvalid` low and `bus_rdata` at zero.
- R2: Word offset 1 is the scratch byte. A write stores data bits 7:0, and a read returns the stored byte.
- R3: Word offset 2 is the index selector. A write stores data bits 7:0, and a read returns the full stored 8-bit index, including values of 16 and above.
- R4: Word offset 3 is the data port. When the index is below 16, a write updates the entry the index selects, and a read returns that entry.
- R5: When the index is 16 or greater, a data-port read returns zero and a data-port write changes no entry.
- R6: Any offset other than 1, 2 or 3 reads as zero. A write to such an offset changes neither the scratch byte, the index nor any entry.
- R7: A read enable sampled at clock edge k sets `bus_rvalid` high for exactly the cycle after edge k, and the read data is presented in that cycle. When `bus_rvalid` is low, `bus_rdata` is zero.
- R8: Only write-data bits 7:0 are stored. Read data bits 31:8 are always zero.
- R9: A write takes effect only when byte-lane mask bit 0 is set. With bit 0 clear, the write changes nothing. Reads ignore the mask.
- R10: When a read and a write target the same location in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ofs | input | OFS_W (4) | Word offset of the access |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_be | input | BUS_W/8 (4) | Byte-lane mask; bit 0 gates writes |
| bus_wdata | input | BUS_W (32) | Write data; bits 7:0 used |
| bus_rdata | output | BUS_W (32) | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read enable |

## Verification
Several properties are checked on every cycle: the valid strobe follows the read enable by one cycle, a dropped write through the data port with an out-of-range index leaves the bank untouched, a write with an in-range index lands in the selected entry, and a write with mask bit 0 clear disturbs neither the scratch byte nor the index. Other behaviour can only be shown by the bench scenarios, which drive the bus against a behavioural model. These cover the reset contents of every entry, readback of large index values, decoding of unused offsets, truncation of wide write data, and a read and write to the same location in one cycle.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int unsigned OFS_SCRATCH = 1;
  localparam int unsigned OFS_INDEX   = 2;
  localparam int unsigned OFS_DATA    = 3;

  typedef struct packed {
    logic wr_scr;
    logic wr_idx;
    logic wr_dat;
    logic rd_scr;
    logic rd_idx;
    logic rd_dat;
  } cfgw_sel_t;
endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             wr,
  input  logic             rd,
  input  logic             lane0,
  output cfgw_sel_t        sel
);
  logic hit_scr, hit_idx, hit_dat, wr_ok;

  always_comb begin
    hit_scr = (ofs == OFS_W'(OFS_SCRATCH));
    hit_idx = (ofs == OFS_W'(OFS_INDEX));
    hit_dat = (ofs == OFS_W'(OFS_DATA));
    wr_ok   = wr & lane0;
    sel.wr_scr = wr_ok & hit_scr;
    sel.wr_idx = wr_ok & hit_idx;
    sel.wr_dat = wr_ok & hit_dat;
    sel.rd_scr = rd & hit_scr;
    sel.rd_idx = rd & hit_idx;
    sel.rd_dat = rd & hit_dat;
  end
endmodule

// File: rtl/cfgw_bank.sv
module cfgw_bank #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DW-1:0] mem;
  logic                     in_range;
  logic [SEL_W-1:0]         slot;

  assign in_range = (int'(idx) < DEPTH);
  assign slot     = idx[SEL_W-1:0];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[e] <= '0;
      end else if (wr && in_range && (int'(slot) == e)) begin
        mem[e] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range) rdata = mem[slot];
  end

  // R5: a write with the index past the bank end leaves every entry alone
  a_r5_oor_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr && (int'(idx) >= DEPTH)) |=> $stable(mem));

  // R4: an in-range write lands in the selected entry
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr && (int'(idx) < DEPTH)) |=> (mem[$past(slot)] == $past(wdata)));
endmodule

// File: rtl/cfgw_rdport.sv
module cfgw_rdport
  import cfgw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  cfgw_sel_t        sel,
  input  logic [DW-1:0]    scr,
  input  logic [DW-1:0]    idx,
  input  logic [DW-1:0]    ent,
  output logic [BUS_W-1:0] rdata,
  output logic             rvalid
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    if (sel.rd_scr) pick = scr;
    if (sel.rd_idx) pick = idx;
    if (sel.rd_dat) pick = ent;
  end

  always_ff @(posedge clk) begin
    if (rst || !rd) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= 1'b1;
      rdata  <= {{(BUS_W-DW){1'b0}}, pick};
    end
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfgw_pkg::*;
#(
  parameter int OFS_W = 4,
  parameter int BUS_W = 32,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFS_W-1:0]   bus_ofs,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W/8-1:0] bus_be,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_rvalid
);
  localparam int IDX_W = DW;

  cfgw_sel_t        sel;
  logic [DW-1:0]    scratch_q;
  logic [IDX_W-1:0] index_q;
  logic [DW-1:0]    ent_rdata;
  logic [DW-1:0]    wbyte;

  assign wbyte = bus_wdata[DW-1:0];

  cfgw_decode #(.OFS_W(OFS_W)) u_dec (
    .ofs(bus_ofs), .wr(bus_wr), .rd(bus_rd), .lane0(bus_be[0]), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      index_q   <= '0;
    end else begin
      if (sel.wr_scr) scratch_q <= wbyte;
      if (sel.wr_idx) index_q   <= wbyte;
    end
  end

  cfgw_bank #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .idx(index_q), .wr(sel.wr_dat),
    .wdata(wbyte), .rdata(ent_rdata)
  );

  cfgw_rdport #(.DW(DW), .BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel),
    .scr(scratch_q), .idx(index_q), .ent(ent_rdata),
    .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

  // R7: the valid strobe follows the read enable by one cycle
  a_r7_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

  // R9: mask bit 0 clear keeps scratch and index unchanged
  a_r9_lane_gate: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_be[0]) |=> ($stable(scratch_q) && $stable(index_q)));

  // R6: writes to unused offsets leave scratch and index unchanged
  a_r6_unused_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_ofs) != OFS_SCRATCH && int'(bus_ofs) != OFS_INDEX)
      |=> ($stable(scratch_q) && $stable(index_q)));
endmodule

// File: tb/sim_cfg_window.sv
module sim_cfg_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_ofs = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  cfg_window u0 (
    .clk(clk), .rst(rst), .bus_ofs(bus_ofs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  // Behavioural reference model
  int m_scr = 0;
  int m_idx = 0;
  int m_bank[16];
  int m_rdata = 0;
  bit m_rvalid = 0;

  function automatic int model_read(input int ofs);
    case (ofs)
      1: return m_scr;
      2: return m_idx;
      3: return (m_idx < 16) ? m_bank[m_idx] : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_scr <= 0; m_idx <= 0; m_rvalid <= 0; m_rdata <= 0;
      for (int i = 0; i < 16; i++) m_bank[i] <= 0;
    end else begin
      m_rvalid <= bus_rd;
      m_rdata  <= bus_rd ? model_read(int'(bus_ofs)) : 0;
      if (bus_wr && bus_be[0]) begin
        case (int'(bus_ofs))
          1: m_scr <= int'(bus_wdata & 32'hFF);
          2: m_idx <= int'(bus_wdata & 32'hFF);
          3: if (m_idx < 16) m_bank[m_idx] <= int'(bus_wdata & 32'hFF);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (bus_rvalid !== m_rvalid || bus_rdata !== 32'(m_rdata)) begin
        fails++;
        $display("FAIL %s: rvalid=%0b rdata=%08h expected rvalid=%0b rdata=%08h",
                 cur_req, bus_rvalid, bus_rdata, m_rvalid, 32'(m_rdata));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic op(input bit w, input bit r, input int ofs, input logic [31:0] d,
                    input logic [3:0] be);
    bus_wr = w; bus_rd = r; bus_ofs = 4'(ofs); bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; bus_be = '0;
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    op(1, 0, ofs, d, 4'hF);
  endtask

  task automatic rd(input int ofs);
    op(0, 1, ofs, 32'h0, 4'h0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: outputs held quiet during reset
    checks++;
    if (bus_rvalid !== 1'b0 || bus_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R1: rvalid=%0b rdata=%08h expected 0 00000000", bus_rvalid, bus_rdata);
    end
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    rd(1); rd(2); rd(3);
    for (int i = 0; i < 16; i++) begin wr(2, 32'(i)); rd(3); end

    cur_req = "R2";
    wr(1, 32'hA5); rd(1); wr(1, 32'h3C); rd(1);

    cur_req = "R3";
    wr(2, 32'hC7); rd(2); wr(2, 32'h10); rd(2);

    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin wr(2, 32'(i)); wr(3, 32'(i * 17 + 3)); end
    for (int i = 15; i >= 0; i -= 3) begin wr(2, 32'(i)); rd(3); end

    cur_req = "R5";
    wr(2, 32'd16);  wr(3, 32'h5A); rd(3);
    wr(2, 32'd200); wr(3, 32'h77); rd(3);
    wr(2, 32'd255); rd(3);
    for (int i = 0; i < 16; i++) begin wr(2, 32'(i)); rd(3); end

    cur_req = "R6";
    wr(0, 32'hEE); wr(4, 32'hDD); wr(15, 32'hCC);
    rd(0); rd(4); rd(15); rd(1); rd(2);
    wr(2, 32'd5); rd(3);

    cur_req = "R7";
    rd(1); rd(2); rd(3); @(negedge clk); @(negedge clk); rd(1);

    cur_req = "R8";
    wr(1, 32'hFFFF_FF12); rd(1);
    wr(3, 32'hABCD_EF99); rd(3);

    cur_req = "R9";
    op(1, 0, 1, 32'h44, 4'b1110); rd(1);
    op(1, 0, 2, 32'h09, 4'b0010); rd(2);
    op(1, 0, 3, 32'h66, 4'b1000); rd(3);
    op(1, 0, 1, 32'h81, 4'b0001); op(0, 1, 1, 32'h0, 4'b0000);

    cur_req = "R10";
    op(1, 1, 1, 32'h5F, 4'hF); rd(1);
    op(1, 1, 3, 32'h2B, 4'hF); rd(3);
    op(1, 1, 2, 32'h07, 4'hF); rd(2); rd(3);

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule